// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block runs conversion commands for an analog-to-digital converter. The commands sit in a shared 64-entry command memory, and that memory is split into two queues. Queue 1 starts at address 0 and has the higher priority. Queue 2 starts at a programmable base address. Each queue is started by its own trigger strobe.

For every command the sequencer selects the channel and steps the converter through three phases: initial sample, final sample and resolution. It then writes the converted value into the result-table entry that has the same address as the command. A queue stops in two ways:

- It ends at an end-of-queue code, at the start of queue 2 (queue 1 only) or at the last memory address.
- It suspends on a command whose pause bit is set, and waits for its next trigger.

A queue-1 trigger cuts into a running queue 2. Queue 2 then starts again from the start of its current subqueue.

The control is one state machine:

- `S_IDLE` picks the pending queue, and queue 1 wins.
- `S_CHECK` reads the command at the queue pointer. It either ends the queue (`S_CHECK -> S_IDLE`) or latches the command (`S_CHECK -> S_INIT`).
- `S_INIT -> S_FINAL` is taken when the initial-sample timer expires.
- `S_FINAL -> S_RESOLVE` is taken when the final-sample timer expires.
- From `S_RESOLVE`, on converter done, the machine goes to `S_CHECK` for the next command, or to `S_IDLE` on a pause or at the last address.
- Any state other than `S_IDLE` goes to `S_IDLE` when queue 2 is aborted by queue 1.

Top module: `convq_seq`

## Requirements
- R1: A trigger starts its queue only when the queue is enabled, armed and not already pending. A trigger for a queue that is pending (running or waiting to run) or disabled is ignored.
- R2: Each command runs its initial sample for 2 cycles (`ph_init_o`), then its final sample (`ph_final_o`) for 2, 4, 8 or 16 cycles for sample-time codes 0 to 3, then resolution (`ph_resolve_o`) until `conv_done_i`.
- R3: The command word is laid out as follows: bits [5:0] are the channel, bits [7:6] the sample-time code and bit 8 the pause bit. `chan_sel_o` shows the channel of the command being converted.
- R4: On `conv_done_i` during resolution, `res_we_o` pulses for one cycle. `res_addr_o` carries the command's address and `res_data_o` carries `conv_data_i`.
- R5: A command whose channel is 63 (6'h3F) ends the queue. It is not converted and it writes no result.
- R6: Queue 1 runs from address 0 and ends on reaching `q2_base_i`. Queue 2 runs from `q2_base_i`. Either queue ends after the command at address 63.
- R7: When a queue ends, its bit in `done_flag_o` is set. Its bit in `irq_o` is high while a flag of that queue is set and its interrupt enable is 1. Both flags of a queue clear when a trigger for it is accepted, and are 0 after reset.
- R8: A command with its pause bit set finishes and writes its result. The queue then sets its pause flag and waits. Its next trigger continues at the following command.
- R9: In single-scan mode (`q_cont_i` bit = 0), a completed pass disarms the queue until its enable goes low and high again. In continuous mode the queue accepts the next trigger directly.
- R10: A queue-1 trigger accepted while queue 2 is active aborts queue 2's command without a result write, and queue 1 runs. Queue 2 then restarts at its first command, or at the command after its last pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 2 | Trigger strobes, bit 0 = queue 1, bit 1 = queue 2 |
| q_en_i | input | 2 | Queue enables; a rising edge arms the queue |
| q_cont_i | input | 2 | Scan mode per queue, 1 = continuous |
| q_irq_en_i | input | 2 | Interrupt enable per queue |
| q2_base_i | input | 6 | First command address of queue 2 |
| cmd_addr_o | output | 6 | Command memory read address |
| cmd_word_i | input | 9 | Command word at `cmd_addr_o` (combinational read) |
| conv_done_i | input | 1 | Converter finished resolution |
| conv_data_i | input | 10 | Converter result |
| chan_sel_o | output | 6 | Selected input channel |
| ph_init_o | output | 1 | Initial-sample phase active |
| ph_final_o | output | 1 | Final-sample phase active |
| ph_resolve_o | output | 1 | Resolution phase active |
| res_we_o | output | 1 | Result table write enable |
| res_addr_o | output | 6 | Result table write address |
| res_data_o | output | 10 | Result table write data |
| pause_flag_o | output | 2 | Pause flags per queue |
| done_flag_o | output | 2 | Completion flags per queue |
| irq_o | output | 2 | Interrupt requests per queue |

## Verification
Each run is tried with a different mix of commands and queue settings, and each mix is chosen to separate one behaviour from the others:

- A queue of mixed sample-time codes ended by the end code shows whether the code sets the final-sample length and whether the end code is wrongly converted.
- Queue 1 with no end code, stopped only by the queue-2 base, shows the boundary rule. Queue 2 placed at the top of memory shows the physical end.
- A paused queue 2 that is then cut into by queue 1 during a long final sample tells a restart from the subqueue apart from a restart at the queue start or a resume at the aborted command. The order of the logged write addresses makes this visible.
- Repeated triggers while a queue is busy, while it is disabled, and after a single-scan pass separate the three ignore rules from continuous-mode re-arming.

// File: rtl/convq_pkg.sv
`timescale 1ns/1ps
package convq_pkg;
    localparam int CH_W      = 6;
    localparam int STIME_W   = 2;
    localparam int CMD_W     = CH_W + STIME_W + 1;
    localparam logic [CH_W-1:0] END_CODE = '1;

    typedef struct packed {
        logic               pause;
        logic [STIME_W-1:0] stime;
        logic [CH_W-1:0]    chan;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_INIT,
        S_FINAL,
        S_RESOLVE
    } seq_state_t;
endpackage

// File: rtl/convq_timer.sv
`timescale 1ns/1ps
module convq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load_i)     cnt <= load_val_i;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/convq_queue.sv
`timescale 1ns/1ps
module convq_queue #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          en_i,
    input  logic          cont_i,
    input  logic          irq_en_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] nxt_i,
    input  logic          adv_i,
    input  logic          pause_i,
    input  logic          done_i,
    input  logic          abort_i,
    output logic          pend_o,
    output logic [AW-1:0] ptr_o,
    output logic          pflag_o,
    output logic          cflag_o,
    output logic          irq_o
);
    logic          armed, en_d, paused;
    logic [AW-1:0] sub;
    logic          accept;

    assign accept = trig_i && en_i && armed && !pend_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            en_d    <= 1'b0;
            paused  <= 1'b0;
            pend_o  <= 1'b0;
            ptr_o   <= '0;
            sub     <= '0;
            pflag_o <= 1'b0;
            cflag_o <= 1'b0;
        end else begin
            en_d <= en_i;
            if (accept) begin
                pend_o  <= 1'b1;
                paused  <= 1'b0;
                pflag_o <= 1'b0;
                cflag_o <= 1'b0;
                if (!paused) begin
                    ptr_o <= base_i;
                    sub   <= base_i;
                end
            end
            if (adv_i) ptr_o <= nxt_i;
            if (abort_i) ptr_o <= sub;
            if (pause_i) begin
                ptr_o   <= nxt_i;
                sub     <= nxt_i;
                pend_o  <= 1'b0;
                paused  <= 1'b1;
                pflag_o <= 1'b1;
            end
            if (done_i) begin
                pend_o  <= 1'b0;
                paused  <= 1'b0;
                cflag_o <= 1'b1;
                if (!cont_i) armed <= 1'b0;
            end
            if (en_i && !en_d) armed <= 1'b1;
        end
    end

    assign irq_o = irq_en_i && (pflag_o || cflag_o);

    AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && trig_i && !pause_i && !done_i) |=> pend_o); // R1
    AST_DISABLED_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !en_i) |=> !pend_o); // R1
    AST_PAUSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |=> (pflag_o && !pend_o)); // R8
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (cflag_o && !pend_o)); // R7
endmodule

// File: rtl/convq_seq.sv
`timescale 1ns/1ps
module convq_seq
    import convq_pkg::*;
#(
    parameter int AW       = 6,
    parameter int RW       = 10,
    parameter int INIT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       trig_i,
    input  logic [1:0]       q_en_i,
    input  logic [1:0]       q_cont_i,
    input  logic [1:0]       q_irq_en_i,
    input  logic [AW-1:0]    q2_base_i,
    output logic [AW-1:0]    cmd_addr_o,
    input  logic [CMD_W-1:0] cmd_word_i,
    input  logic             conv_done_i,
    input  logic [RW-1:0]    conv_data_i,
    output logic [CH_W-1:0]  chan_sel_o,
    output logic             ph_init_o,
    output logic             ph_final_o,
    output logic             ph_resolve_o,
    output logic             res_we_o,
    output logic [AW-1:0]    res_addr_o,
    output logic [RW-1:0]    res_data_o,
    output logic [1:0]       pause_flag_o,
    output logic [1:0]       done_flag_o,
    output logic [1:0]       irq_o
);
    localparam int TW = STIME_W + 3;
    localparam logic [AW-1:0] LAST_ADDR = '1;

    seq_state_t    st, st_n;
    logic          act, act_n;
    cmd_t          cur_cmd, cmd_n, cmd_in;
    logic [1:0]    pend;
    logic [AW-1:0] qptr [2];
    logic [AW-1:0] base [2];
    logic [AW-1:0] nxt;
    logic [1:0]    ev_adv, ev_pause, ev_done, ev_abort;
    logic          tmr_load, tmr_exp, abort, eoq;
    logic [TW-1:0] tmr_val;

    assign cmd_in = cmd_word_i;
    assign nxt    = qptr[act] + 1'b1;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_queue
            if (g == 0) begin : g_base_lo
                assign base[g] = '0;
            end else begin : g_base_hi
                assign base[g] = q2_base_i;
            end
            convq_queue #(.AW(AW)) u_queue (
                .clk      (clk),
                .rst_n    (rst_n),
                .trig_i   (trig_i[g]),
                .en_i     (q_en_i[g]),
                .cont_i   (q_cont_i[g]),
                .irq_en_i (q_irq_en_i[g]),
                .base_i   (base[g]),
                .nxt_i    (nxt),
                .adv_i    (ev_adv[g]),
                .pause_i  (ev_pause[g]),
                .done_i   (ev_done[g]),
                .abort_i  (ev_abort[g]),
                .pend_o   (pend[g]),
                .ptr_o    (qptr[g]),
                .pflag_o  (pause_flag_o[g]),
                .cflag_o  (done_flag_o[g]),
                .irq_o    (irq_o[g])
            );
        end
    endgenerate

    convq_timer #(.CNT_W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            act     <= 1'b0;
            cur_cmd <= '0;
        end else begin
            st      <= st_n;
            act     <= act_n;
            cur_cmd <= cmd_n;
        end
    end

    assign abort = act && pend[0] && (st != S_IDLE);
    assign eoq   = (cmd_in.chan == END_CODE) || (!act && qptr[0] == q2_base_i);

    // next state and queue events
    always_comb begin
        st_n     = st;
        act_n    = act;
        cmd_n    = cur_cmd;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ev_adv   = '0;
        ev_pause = '0;
        ev_done  = '0;
        ev_abort = '0;
        if (abort) begin
            st_n        = S_IDLE;
            ev_abort[1] = 1'b1;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (pend[0]) begin
                        act_n = 1'b0;
                        st_n  = S_CHECK;
                    end else if (pend[1]) begin
                        act_n = 1'b1;
                        st_n  = S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (eoq) begin
                        ev_done[act] = 1'b1;
                        st_n         = S_IDLE;
                    end else begin
                        cmd_n    = cmd_in;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(INIT_CYC - 1);
                        st_n     = S_INIT;
                    end
                end
                S_INIT: begin
                    if (tmr_exp) begin
                        tmr_load = 1'b1;
                        tmr_val  = (TW'(2) << cur_cmd.stime) - 1'b1;
                        st_n     = S_FINAL;
                    end
                end
                S_FINAL: begin
                    if (tmr_exp) st_n = S_RESOLVE;
                end
                S_RESOLVE: begin
                    if (conv_done_i) begin
                        if (qptr[act] == LAST_ADDR) begin
                            ev_done[act] = 1'b1;
                            st_n         = S_IDLE;
                        end else if (cur_cmd.pause) begin
                            ev_pause[act] = 1'b1;
                            st_n          = S_IDLE;
                        end else begin
                            ev_adv[act] = 1'b1;
                            st_n        = S_CHECK;
                        end
                    end
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_addr_o   = qptr[act];
        chan_sel_o   = cur_cmd.chan;
        ph_init_o    = (st == S_INIT);
        ph_final_o   = (st == S_FINAL);
        ph_resolve_o = (st == S_RESOLVE);
        res_we_o     = (st == S_RESOLVE) && conv_done_i && !abort;
        res_addr_o   = qptr[act];
        res_data_o   = conv_data_i;
    end

    AST_FINAL_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_final_o) |-> $past(ph_init_o)); // R2
    AST_RESOLVE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_resolve_o) |-> $past(ph_final_o)); // R2
    AST_WRITE_IN_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_o |-> (ph_resolve_o && conv_done_i)); // R4
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_o |=> !res_we_o); // R4
    AST_Q1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we_o && !act) |-> (res_addr_o < q2_base_i)); // R6
    AST_PREEMPT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && act && pend[0]) |=> (st == S_IDLE && !ph_resolve_o)); // R10
    AST_NO_WRITE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (act && pend[0]) |-> !res_we_o); // R10
endmodule

// File: tb/convq_seq_bench.sv
`timescale 1ns/1ps
module convq_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  trig = '0, q_en = '0, q_cont = '0, q_irq_en = '0;
    logic [5:0]  q2_base = 6'd8;
    logic [5:0]  cmd_addr;
    logic [8:0]  cmd_word;
    logic        conv_done;
    logic [9:0]  conv_data;
    logic [5:0]  chan_sel, res_addr;
    logic        ph_init, ph_final, ph_resolve, res_we;
    logic [9:0]  res_data;
    logic [1:0]  pause_flag, done_flag, irq;

    logic [8:0]  mem [64];
    logic [9:0]  rtab [64];
    logic [5:0]  wlog [256];
    int          wn = 0;
    int          flen [256];
    int          fn = 0, fcur = 0, icur = 0, ilast = 0;
    int          rcnt = 0;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    assign cmd_word  = mem[cmd_addr];
    assign conv_done = ph_resolve && (rcnt == 3);
    assign conv_data = {4'hA, chan_sel};

    convq_seq u_convq_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .q_en_i(q_en), .q_cont_i(q_cont),
        .q_irq_en_i(q_irq_en), .q2_base_i(q2_base), .cmd_addr_o(cmd_addr),
        .cmd_word_i(cmd_word), .conv_done_i(conv_done), .conv_data_i(conv_data),
        .chan_sel_o(chan_sel), .ph_init_o(ph_init), .ph_final_o(ph_final),
        .ph_resolve_o(ph_resolve), .res_we_o(res_we), .res_addr_o(res_addr),
        .res_data_o(res_data), .pause_flag_o(pause_flag), .done_flag_o(done_flag),
        .irq_o(irq)
    );

    // converter model and monitors
    always @(posedge clk) begin
        rcnt <= ph_resolve ? rcnt + 1 : 0;
        if (res_we) begin
            rtab[res_addr] <= res_data;
            if (wn < 256) wlog[wn] <= res_addr;
            wn <= wn + 1;
        end
        if (ph_final) fcur <= fcur + 1;
        else if (fcur != 0) begin
            if (fn < 256) flen[fn] <= fcur;
            fn   <= fn + 1;
            fcur <= 0;
        end
        if (ph_init) icur <= icur + 1;
        else if (icur != 0) begin
            ilast <= icur;
            icur  <= 0;
        end
    end

    function automatic logic [9:0] expd(input logic [5:0] ch);
        return {4'hA, ch};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setcmd(input int a, input bit p, input int code, input int ch);
        mem[a] = {p, 2'(code), 6'(ch)};
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 9'h03F;
    endtask

    task automatic pulse(input int q);
        @(negedge clk); trig[q] = 1'b1;
        @(negedge clk); trig[q] = 1'b0;
    endtask

    task automatic rearm(input int q);
        @(negedge clk); q_en[q] = 1'b0;
        @(negedge clk); q_en[q] = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input int q);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done_flag[q]) break;
        end
        idle(2);
    endtask

    task automatic wait_pause(input int q);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (pause_flag[q]) break;
        end
        idle(2);
    endtask

    task automatic t_reset();
        chk(res_we == 0 && ph_init == 0 && ph_final == 0 && ph_resolve == 0, "R2 reset phases idle", int'(res_we), 0);
        chk(done_flag == 0 && pause_flag == 0 && irq == 0, "R7 reset flags clear", int'({done_flag, pause_flag, irq}), 0);
    endtask

    task automatic t_basic();
        int b, fb;
        clear_mem();
        setcmd(0, 0, 0, 5); setcmd(1, 0, 1, 6); setcmd(2, 0, 3, 7);
        b = wn; fb = fn;
        pulse(0);
        wait_done(0);
        chk(wn - b == 3, "R5 end code writes nothing", wn - b, 3);
        chk(wlog[b] == 0 && wlog[b+1] == 1 && wlog[b+2] == 2, "R4 write addresses", int'(wlog[b+2]), 2);
        chk(rtab[0] == expd(5) && rtab[1] == expd(6), "R3 channel in result", int'(rtab[1]), int'(expd(6)));
        chk(rtab[2] == expd(7), "R4 result data", int'(rtab[2]), int'(expd(7)));
        chk(flen[fb] == 2, "R2 final code 0", flen[fb], 2);
        chk(flen[fb+1] == 4, "R2 final code 1", flen[fb+1], 4);
        chk(flen[fb+2] == 16, "R2 final code 3", flen[fb+2], 16);
        chk(ilast == 2, "R2 initial length", ilast, 2);
        chk(done_flag[0] == 1 && irq[0] == 1, "R7 completion flag and irq", int'({done_flag[0], irq[0]}), 3);
        @(negedge clk); q_irq_en[0] = 1'b0;
        @(negedge clk);
        chk(irq[0] == 0, "R7 irq masked", int'(irq[0]), 0);
        q_irq_en[0] = 1'b1;
    endtask

    task automatic t_single();
        int b;
        b = wn;
        pulse(0); idle(100);
        chk(wn == b && done_flag[0] == 1, "R9 single scan disarmed", wn - b, 0);
        rearm(0);
        pulse(0);
        chk(done_flag[0] == 0, "R7 flag cleared on accept", int'(done_flag[0]), 0);
        wait_done(0);
        chk(wn - b == 3, "R9 rearm after enable edge", wn - b, 3);
    endtask

    task automatic t_busy();
        int b;
        rearm(0);
        b = wn;
        pulse(0); idle(10); pulse(0);
        wait_done(0); idle(100);
        chk(wn - b == 3, "R1 trigger while busy ignored", wn - b, 3);
    endtask

    task automatic t_disabled();
        int b;
        b = wn;
        @(negedge clk); q_en[1] = 1'b0;
        pulse(1); idle(100);
        chk(wn == b && done_flag[1] == 0, "R1 disabled trigger ignored", wn - b, 0);
        @(negedge clk); q_en[1] = 1'b1;
        idle(1);
    endtask

    task automatic t_q1_bound();
        int b;
        clear_mem();
        setcmd(0, 0, 0, 1); setcmd(1, 0, 0, 2); setcmd(2, 0, 0, 3); setcmd(3, 0, 0, 9);
        q2_base = 6'd3;
        rearm(0);
        b = wn;
        pulse(0); wait_done(0);
        chk(wn - b == 3 && wlog[b+2] == 2, "R6 queue 1 ends at queue 2 base", wn - b, 3);
        q2_base = 6'd8;
    endtask

    task automatic t_phys_end();
        int b;
        clear_mem();
        setcmd(62, 0, 0, 4); setcmd(63, 0, 0, 5);
        q2_base = 6'd62;
        rearm(1);
        b = wn;
        pulse(1); wait_done(1);
        chk(wn - b == 2 && wlog[b] == 62 && wlog[b+1] == 63, "R6 physical end", wn - b, 2);
        chk(rtab[63] == expd(5) && done_flag[1] == 1, "R6 last entry then complete", int'(rtab[63]), int'(expd(5)));
        q2_base = 6'd8;
    endtask

    task automatic t_cont();
        int b;
        clear_mem();
        setcmd(8, 0, 0, 11);
        q_cont[1] = 1'b1;
        rearm(1);
        b = wn;
        pulse(1); wait_done(1);
        pulse(1); wait_done(1);
        chk(wn - b == 2 && done_flag[1] == 1, "R9 continuous rearms", wn - b, 2);
        q_cont[1] = 1'b0;
    endtask

    task automatic t_pause();
        int b;
        clear_mem();
        setcmd(8, 1, 0, 12); setcmd(9, 0, 0, 13);
        rearm(1);
        b = wn;
        pulse(1); wait_pause(1); idle(50);
        chk(wn - b == 1 && wlog[b] == 8, "R8 pause after command", wn - b, 1);
        chk(pause_flag[1] == 1 && irq[1] == 1 && done_flag[1] == 0, "R8 pause flag", int'({pause_flag[1], irq[1], done_flag[1]}), 6);
        pulse(1);
        chk(pause_flag[1] == 0, "R8 pause flag cleared on resume", int'(pause_flag[1]), 0);
        wait_done(1);
        chk(wn - b == 2 && wlog[b+1] == 9, "R8 resume at next command", int'(wlog[b+1]), 9);
    endtask

    task automatic t_preempt();
        int b;
        clear_mem();
        setcmd(0, 0, 0, 1);
        setcmd(8, 1, 0, 12); setcmd(9, 0, 3, 20); setcmd(10, 0, 0, 21);
        rearm(0); rearm(1);
        b = wn;
        pulse(1); wait_pause(1);
        pulse(1);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (ph_final && chan_sel == 6'd20) break;
        end
        idle(3);
        pulse(0);
        wait_done(0); wait_done(1);
        chk(wn - b == 4, "R10 write count", wn - b, 4);
        chk(wlog[b+1] == 0, "R10 queue 1 runs before aborted command", int'(wlog[b+1]), 0);
        chk(wlog[b+2] == 9 && wlog[b+3] == 10, "R10 restart at subqueue", int'(wlog[b+2]), 9);
        chk(rtab[9] == expd(20), "R10 restarted result", int'(rtab[9]), int'(expd(20)));
    endtask

    initial begin
        clear_mem();
        for (int i = 0; i < 64; i++) rtab[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        q_en = 2'b11; q_irq_en = 2'b11;
        idle(2);
        t_basic();
        t_single();
        t_busy();
        t_disabled();
        t_q1_bound();
        t_phys_end();
        t_cont();
        t_pause();
        t_preempt();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule